// File: doc/BRIEF.md
# Per-CPU Interval Tick Ignore Counters

This block decides, for every interval timer tick, whether each of up to four processors should receive a timer interrupt. Every processor owns one counter. Software loads a count through a 64-bit register write port and may read the counter back through the same port at any time.

A tick is the rising edge of an asynchronous timer request level. The level is synchronised inside the block before the edge is detected. On a tick, every counter steps down by one, and the count keeps going through zero instead of stopping there. The top bit of each counter is a sticky overflow flag. Once it is set, every later tick produces a one-cycle `timer_set` pulse for that processor. A separate status register uses that pulse to set the processor's timer bit. Loading a counter clears its overflow flag, which stops delivery until the count runs out again.

Top module: `tick_ignore_ctr`

## Requirements
- R1: After reset every counter reads back as zero, its overflow flag is clear, and every `timer_set` bit is low.
- R2: A write to a counter's offset loads `csr_wdata[CNT_W-1:0]` into the count and clears the overflow flag. Written data bits at and above CNT_W have no effect.
- R3: Processor 0, 1, 2 and 3 counters sit at byte offsets 0x380, 0x3C0, 0x700 and 0x740. A read of any other offset returns zero. A write to any other offset changes no counter.
- R4: Only a low-to-high transition of `timer_req` is a tick. Holding the level high, or taking it low, changes no counter and produces no pulse.
- R5: On a tick, each counter's (CNT_W+1)-bit value is decremented modulo 2^(CNT_W+1), and the overflow flag (bit CNT_W) is then ORed with its value before the tick, so it stays set once set.
- R6: When a counter's overflow flag is set after a tick's decrement, its `timer_set` bit is high for exactly one clock cycle. The pulse is visible after the third rising clock edge following the rise of `timer_req`, and is never produced in any other cycle.
- R7: All counters step on the same tick, each from its own value.
- R8: When a write and a tick reach the same counter in the same cycle, the write wins. The counter takes the written value with the flag clear, and that processor receives no pulse for that tick.
- R9: Read data is registered and appears in the cycle after the read strobe. It holds the count in bits CNT_W-1:0 and the overflow flag in bit CNT_W, and all higher bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| timer_req | input | 1 | Asynchronous interval timer request level |
| csr_wr_en | input | 1 | Register write strobe |
| csr_rd_en | input | 1 | Register read strobe |
| csr_addr | input | ADDR_W (12) | Register byte offset |
| csr_wdata | input | DATA_W (64) | Write data |
| csr_rdata | output | DATA_W (64) | Registered read data |
| timer_set | output | NUM_CPU (4) | Per-processor one-cycle timer-set pulse |

## Verification
The bench builds the block with CNT_W = 4 and four processors. A counter therefore runs out within sixteen ticks, so the wrap through zero, the moment the flag is set and the pulses that follow all become reachable. All sixteen load values are swept across the four counters at once, with a different value in each, and more than sixteen ticks are applied after each load. The expected values come from an arithmetic model of the decrement. Held and falling request levels, unmapped offsets, stray high write data bits and a write that collides with a tick are also driven at this small width.

// File: rtl/tick_ignore_pkg.sv
package tick_ignore_pkg;

  localparam int unsigned LOW_BANK_BASE  = 32'h380;
  localparam int unsigned HIGH_BANK_BASE = 32'h700;
  localparam int unsigned SLOT_STRIDE    = 32'h40;
  localparam int unsigned LOW_BANK_SLOTS = 2;

  // Byte offset of the counter belonging to processor idx.
  function automatic int unsigned slot_offset(input int unsigned idx);
    if (idx < LOW_BANK_SLOTS)
      return LOW_BANK_BASE + idx * SLOT_STRIDE;
    else
      return HIGH_BANK_BASE + (idx - LOW_BANK_SLOTS) * SLOT_STRIDE;
  endfunction

endpackage

// File: rtl/tick_ignore_rst_sync.sv
module tick_ignore_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tick_ignore_edge.sv
module tick_ignore_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_async,
  output logic tick
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;
  logic                   level_s;

  assign level_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], level_async};
    prev_d = level_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign tick = level_s & ~prev_q;

  // R4: a tick is followed by a cycle without one, since the level is already seen high
  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tick_ignore_slice.sv
module tick_ignore_slice #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W:0]   value,
  output logic             set_pulse
);
  localparam int VAL_W = CNT_W + 1;
  localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

  logic [VAL_W-1:0] val_q, val_d;
  logic [VAL_W-1:0] dec;
  logic             val_en;
  logic             pulse_q, pulse_d;

  always_comb begin
    dec     = val_q - ONE;
    val_d   = val_q;
    pulse_d = 1'b0;
    val_en  = load | tick;
    if (load) begin
      val_d = {1'b0, load_val};
    end else if (tick) begin
      val_d   = {dec[CNT_W] | val_q[CNT_W], dec[CNT_W-1:0]};
      pulse_d = dec[CNT_W] | val_q[CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (val_en) val_q <= val_d;
      pulse_q <= pulse_d;
    end
  end

  assign value     = val_q;
  assign set_pulse = pulse_q;

  assert_load_clears_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (value[CNT_W] == 1'b0) && (value[CNT_W-1:0] == $past(load_val)));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(value));

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (value[CNT_W] && !load) |=> value[CNT_W]);

  assert_tick_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> value != $past(value));

  assert_pulse_has_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |-> value[CNT_W]);

  assert_collision_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !set_pulse);
endmodule

// File: rtl/tick_ignore_decode.sv
module tick_ignore_decode
  import tick_ignore_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CPU-1:0] wr_sel,
  output logic [NUM_CPU-1:0] rd_sel
);
  for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(slot_offset(g));
    logic hit;
    assign hit       = (addr == OFFS);
    assign wr_sel[g] = wr_en & hit;
    assign rd_sel[g] = rd_en & hit;
  end

  // R3: one address selects at most one counter
  always_comb begin
    assert_one_slot_R3: assert ($onehot0(wr_sel));
  end
endmodule

// File: rtl/tick_ignore_ctr.sv
module tick_ignore_ctr #(
  parameter int NUM_CPU     = 4,
  parameter int CNT_W       = 24,
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               timer_req,
  input  logic               csr_wr_en,
  input  logic               csr_rd_en,
  input  logic [ADDR_W-1:0]  csr_addr,
  input  logic [DATA_W-1:0]  csr_wdata,
  output logic [DATA_W-1:0]  csr_rdata,
  output logic [NUM_CPU-1:0] timer_set
);
  localparam int VAL_W = CNT_W + 1;

  logic               rst_n_i;
  logic               tick;
  logic [NUM_CPU-1:0] wr_sel;
  logic [NUM_CPU-1:0] rd_sel;
  logic [VAL_W-1:0]   value [NUM_CPU];
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic               unused_wdata_hi;

  assign unused_wdata_hi = ^csr_wdata[DATA_W-1:CNT_W];

  tick_ignore_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  tick_ignore_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .level_async (timer_req),
    .tick        (tick)
  );

  tick_ignore_decode #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_dec (
    .wr_en  (csr_wr_en),
    .rd_en  (csr_rd_en),
    .addr   (csr_addr),
    .wr_sel (wr_sel),
    .rd_sel (rd_sel)
  );

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    tick_ignore_slice #(.CNT_W(CNT_W)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n_i),
      .load      (wr_sel[g]),
      .load_val  (csr_wdata[CNT_W-1:0]),
      .tick      (tick),
      .value     (value[g]),
      .set_pulse (timer_set[g])
    );
  end

  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < NUM_CPU; i++) begin
      if (rd_sel[i]) rdata_d = rdata_d | DATA_W'(value[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)       rdata_q <= '0;
    else if (csr_rd_en) rdata_q <= rdata_d;
  end

  assign csr_rdata = rdata_q;

  assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (csr_rd_en && !(|rd_sel)) |=> csr_rdata == '0);

  assert_pulse_follows_tick_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (|timer_set) |-> $past(tick));

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    csr_rdata[DATA_W-1:VAL_W] == '0);
endmodule

// File: tb/tick_ignore_ctr_test.sv
module tick_ignore_ctr_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;
  localparam int CW   = 4;
  localparam int VW   = CW + 1;
  localparam int AW   = 12;
  localparam int DW   = 64;
  localparam int OFFS [NCPU] = '{'h380, 'h3C0, 'h700, 'h740};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          timer_req;
  logic          csr_wr_en;
  logic          csr_rd_en;
  logic [AW-1:0] csr_addr;
  logic [DW-1:0] csr_wdata;
  logic [DW-1:0] csr_rdata;
  logic [NCPU-1:0] timer_set;

  int n_checks = 0;
  int n_fails  = 0;
  logic [VW-1:0] model [NCPU];

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_ignore_ctr #(.NUM_CPU(NCPU), .CNT_W(CW), .DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .timer_req (timer_req),
    .csr_wr_en (csr_wr_en),
    .csr_rd_en (csr_rd_en),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .timer_set (timer_set)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr_write(input int addr, input logic [DW-1:0] data);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_addr = AW'(addr); csr_wdata = data;
    @(negedge clk);
    csr_wr_en = 1'b0;
  endtask

  task automatic csr_read(input int addr, output logic [DW-1:0] data);
    @(negedge clk);
    csr_rd_en = 1'b1; csr_addr = AW'(addr);
    @(negedge clk);
    csr_rd_en = 1'b0;
    data = csr_rdata;
  endtask

  function automatic logic [VW-1:0] step(input logic [VW-1:0] v);
    logic [VW-1:0] n;
    n = v - VW'(1);
    n[CW] = n[CW] | v[CW];
    return n;
  endfunction

  task automatic check_all(input string req);
    logic [DW-1:0] rd;
    for (int i = 0; i < NCPU; i++) begin
      csr_read(OFFS[i], rd);
      check(req, rd, DW'(model[i]));
    end
  endtask

  // One tick; the pulse is sampled after the third rising edge and one cycle later.
  task automatic do_tick(input string req);
    logic [NCPU-1:0] expp;
    @(negedge clk); timer_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < NCPU; i++) begin
      model[i] = step(model[i]);
      expp[i]  = model[i][CW];
    end
    check(req, DW'(timer_set), DW'(expp));
    @(negedge clk);
    check({req, " one-cycle R6"}, DW'(timer_set), '0);
    timer_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    logic [NCPU-1:0] expp;
    rst_n = 1'b0; timer_req = 1'b0; csr_wr_en = 1'b0; csr_rd_en = 1'b0;
    csr_addr = '0; csr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int i = 0; i < NCPU; i++) model[i] = '0;
    check("R1 pulses", DW'(timer_set), '0);
    check_all("R1 reset value");

    // R5/R6/R7/R2/R9: sweep all load values, each counter offset differently
    for (int base = 0; base < 16; base++) begin
      for (int i = 0; i < NCPU; i++) begin
        logic [CW-1:0] v;
        v = CW'((base + 5 * i) % 16);
        csr_write(OFFS[i], {60'hA5C3_0F0F_1234_567, v} | (DW'(base) << 20));
        model[i] = {1'b0, v};
      end
      check_all("R2 R9 load readback");
      for (int t = 0; t < 18; t++) begin
        do_tick("R5 R6 R7 tick pulse");
        check_all("R5 R7 count after tick");
      end
    end

    // R2: reload clears a set overflow flag
    csr_write(OFFS[2], DW'(7));
    model[2] = VW'(7);
    check_all("R2 reload clears flag");

    // R3: unmapped offsets
    csr_write('h400, '1);
    csr_write('h384, '1);
    csr_write('h000, '1);
    check_all("R3 unmapped write ignored");
    csr_read('h400, rd);
    check("R3 unmapped read zero", rd, '0);
    csr_read('h744, rd);
    check("R3 unmapped read zero", rd, '0);

    // R4: held high level and falling level give no further ticks
    @(negedge clk); timer_req = 1'b1;
    repeat (12) @(negedge clk);
    for (int i = 0; i < NCPU; i++) model[i] = step(model[i]);
    check_all("R4 held level single tick");
    @(negedge clk); timer_req = 1'b0;
    repeat (6) @(negedge clk);
    check("R4 falling no pulse", DW'(timer_set), '0);
    check_all("R4 falling level ignored");

    // R8: write collides with tick on CPU1 whose flag is set
    csr_write(OFFS[1], DW'(0));
    model[1] = '0;
    do_tick("R8 prep");
    check("R8 prep flag set", DW'(model[1][CW]), DW'(1));
    @(negedge clk); timer_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_addr = AW'(OFFS[1]); csr_wdata = DW'(9);
    @(negedge clk);
    csr_wr_en = 1'b0;
    for (int i = 0; i < NCPU; i++) begin
      model[i] = (i == 1) ? VW'(9) : step(model[i]);
      expp[i]  = (i == 1) ? 1'b0 : model[i][CW];
    end
    check("R8 collision pulses", DW'(timer_set), DW'(expp));
    timer_req = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R8 write wins");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule